// File: doc/BRIEF.md
# Companding Range Code Path

This block carries the 2-bit gain-range code that travels alongside each stored audio sample in a companded delay line. While the converter is digitising input (the A/D cycle), the block turns the threshold flags from the positive and negative peak detectors into a range code. It latches that code once per sample strobe and writes it into a small side memory. The side-memory location is the sample's address plus a small offset chosen by the active audio bank.

While stored audio is being played back (the D/A cycle), a rising edge on a read strobe fetches the code back from the same adjusted location. An output register drives either the live code or the stored code to the attenuator control, which scales the converter range by 1, 10 or 100. The cycle type comes in on two one-hot lines. Any other combination on those lines freezes the output and raises an error flag.

Top module: `rc_range_path`

## Requirements
- R1: The range code on `att_code` uses 0 for scaling 1 (largest range), 1 for scaling 10 and 2 for scaling 100; the value 3 is never driven.
- R2: Each peak input is a 2-bit threshold flag, where bit 0 means the low threshold is exceeded and bit 1 means the high threshold is exceeded. The live code is 0 if bit 1 of either input is set, else 1 if bit 0 of either input is set, else 2. It is captured only at clock edges where `smp_stb` is high and is held otherwise.
- R3: At a clock edge where `smp_stb` is high during an A/D cycle, the newly computed code is written once to side-memory location (`smp_addr` + `bank_sel`) modulo the memory depth. No write occurs in any other cycle type or without `smp_stb`.
- R4: The stored code is loaded from location (`smp_addr` + `bank_sel`) modulo the depth at the first clock edge where `rd_stb` is sampled high after being low. It is held while `rd_stb` stays high or low.
- R5: Cycle lines {`cyc_da`,`cyc_ad`} = 01 select the A/D cycle. One clock later `att_code` equals the latched live code.
- R6: Cycle lines {`cyc_da`,`cyc_ad`} = 10 select the D/A cycle. One clock later `att_code` equals the latched stored code.
- R7: Cycle lines 00 or 11 are illegal. `att_code` keeps its previous value.
- R8: `cyc_err` is high in the clock after an illegal cycle-line pair is sampled, and low in the clock after a legal one.
- R9: Reset (`rst_n` low) drives `att_code` to 0 and `cyc_err` to 0.
- R10: The same `smp_addr` under different `bank_sel` values addresses different side-memory locations. The bank offset adds 0 to 3 to the address and wraps at the top of memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| smp_stb | input | 1 | Per-sample strobe, one clock wide |
| pk_pos | input | 2 | Positive peak threshold flags |
| pk_neg | input | 2 | Negative peak threshold flags |
| cyc_da | input | 1 | D/A (playback) cycle line |
| cyc_ad | input | 1 | A/D (record) cycle line |
| smp_addr | input | AW (6) | Sample address |
| bank_sel | input | BW (2) | Active bank index, used as address offset |
| rd_stb | input | 1 | Side-memory read strobe, acts on its rising edge |
| att_code | output | 2 | Range code to attenuator control |
| cyc_err | output | 1 | Illegal cycle-line flag |

## Verification
On every clock, the embedded properties check the following:
- the output never carries code 3;
- the output follows the live latch in A/D cycles and the stored latch in D/A cycles;
- the output freezes under illegal cycle lines, and the error flag tracks the legality of the lines;
- both latches hold when their strobes are absent.

Only the bench scenarios can show the rest:
- that the peak-to-range mapping is right across all sixteen flag combinations;
- that each code lands in the bank-offset location and wraps at the top of memory;
- that writes are suppressed outside A/D sample strobes;
- that a held-high read strobe does not re-fetch.

// File: rtl/rcp_pkg.sv
package rcp_pkg;

  typedef enum logic [1:0] {
    RC_X1   = 2'd0,
    RC_X10  = 2'd1,
    RC_X100 = 2'd2
  } rc_range_e;

  typedef enum logic [1:0] {
    CYC_AD  = 2'd0,
    CYC_DA  = 2'd1,
    CYC_BAD = 2'd2
  } cyc_kind_e;

  // Strongest threshold crossed on either polarity picks the widest range.
  function automatic logic [1:0] range_from_peaks(input logic [1:0] p, input logic [1:0] n);
    logic [1:0] any;
    any = p | n;
    if (any[1])      return RC_X1;
    else if (any[0]) return RC_X10;
    else             return RC_X100;
  endfunction

  function automatic cyc_kind_e decode_cycle(input logic da, input logic ad);
    case ({da, ad})
      2'b01:   return CYC_AD;
      2'b10:   return CYC_DA;
      default: return CYC_BAD;
    endcase
  endfunction

endpackage

// File: rtl/rc_live_latch.sv
module rc_live_latch
  import rcp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_stb,
  input  logic [1:0] pk_pos,
  input  logic [1:0] pk_neg,
  output logic [1:0] new_code,
  output logic [1:0] live_q
);

  assign new_code = range_from_peaks(pk_pos, pk_neg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       live_q <= RC_X1;
    else if (smp_stb) live_q <= new_code;
  end

  assert_live_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> $stable(live_q));

endmodule

// File: rtl/rc_side_mem.sv
module rc_side_mem #(
  parameter int AW = 6,
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_code,
  input  logic [AW-1:0] smp_addr,
  input  logic [BW-1:0] bank_sel,
  input  logic          rd_stb,
  output logic          rd_rise,
  output logic [1:0]    stored_q
);

  localparam int DEPTH = 1 << AW;

  logic [1:0]    mem [DEPTH];
  logic [AW-1:0] idx;
  logic          rd_stb_q;

  // Bank offset added to the sample address, wrapping at the top.
  assign idx     = smp_addr + {{(AW-BW){1'b0}}, bank_sel};
  assign rd_rise = rd_stb & ~rd_stb_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wr_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_stb_q <= 1'b0;
      stored_q <= 2'd0;
    end else begin
      rd_stb_q <= rd_stb;
      if (rd_rise) stored_q <= mem[idx];
    end
  end

  assert_stored_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_rise |=> $stable(stored_q));

endmodule

// File: rtl/rc_out_sel.sv
module rc_out_sel
  import rcp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cyc_kind_e  cyc,
  input  logic [1:0] live_q,
  input  logic [1:0] stored_q,
  output logic [1:0] att_code,
  output logic       cyc_err
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      att_code <= RC_X1;
      cyc_err  <= 1'b0;
    end else begin
      cyc_err <= (cyc == CYC_BAD);
      case (cyc)
        CYC_AD:  att_code <= live_q;
        CYC_DA:  att_code <= stored_q;
        default: att_code <= att_code;
      endcase
    end
  end

  assert_code_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    att_code != 2'b11);
  assert_ad_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_AD) |=> att_code == $past(live_q));
  assert_da_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_DA) |=> att_code == $past(stored_q));
  assert_bad_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_BAD) |=> $stable(att_code));
  assert_err_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_BAD) |=> cyc_err);
  assert_err_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != CYC_BAD) |=> !cyc_err);

endmodule

// File: rtl/rc_range_path.sv
module rc_range_path
  import rcp_pkg::*;
#(
  parameter int AW = 6,
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_stb,
  input  logic [1:0]    pk_pos,
  input  logic [1:0]    pk_neg,
  input  logic          cyc_da,
  input  logic          cyc_ad,
  input  logic [AW-1:0] smp_addr,
  input  logic [BW-1:0] bank_sel,
  input  logic          rd_stb,
  output logic [1:0]    att_code,
  output logic          cyc_err
);

  cyc_kind_e  cyc;
  logic [1:0] new_code;
  logic [1:0] live_q;
  logic [1:0] stored_q;
  logic       wr_en;
  logic       rd_rise;

  assign cyc   = decode_cycle(cyc_da, cyc_ad);
  // One write per sample, only while recording.
  assign wr_en = smp_stb & (cyc == CYC_AD);

  rc_live_latch u_live (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb),
    .pk_pos(pk_pos), .pk_neg(pk_neg),
    .new_code(new_code), .live_q(live_q)
  );

  rc_side_mem #(.AW(AW), .BW(BW)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_code(new_code),
    .smp_addr(smp_addr), .bank_sel(bank_sel), .rd_stb(rd_stb),
    .rd_rise(rd_rise), .stored_q(stored_q)
  );

  rc_out_sel u_out (
    .clk(clk), .rst_n(rst_n), .cyc(cyc),
    .live_q(live_q), .stored_q(stored_q),
    .att_code(att_code), .cyc_err(cyc_err)
  );

  assert_write_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (smp_stb && cyc_ad && !cyc_da));

endmodule

// File: tb/tb_rc_range_path.sv
module tb_rc_range_path;

  localparam int AW = 6;
  localparam int BW = 2;
  localparam int DEPTH = 64;

  logic clk = 0;
  logic rst_n = 0;
  logic smp_stb = 0;
  logic [1:0] pk_pos = 0, pk_neg = 0;
  logic cyc_da = 0, cyc_ad = 1;
  logic [AW-1:0] smp_addr = 0;
  logic [BW-1:0] bank_sel = 0;
  logic rd_stb = 0;
  logic [1:0] att_code;
  logic cyc_err;

  int tests = 0, fails = 0;
  int model [DEPTH];

  always #10 clk = ~clk;

  rc_range_path #(.AW(AW), .BW(BW)) dut (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .pk_pos(pk_pos), .pk_neg(pk_neg),
    .cyc_da(cyc_da), .cyc_ad(cyc_ad), .smp_addr(smp_addr), .bank_sel(bank_sel),
    .rd_stb(rd_stb), .att_code(att_code), .cyc_err(cyc_err)
  );

  initial begin
    #3_000_000;
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lvl(logic [1:0] f);
    return f[1] ? 2 : (f[0] ? 1 : 0);
  endfunction

  function automatic int exp_code(logic [1:0] p, logic [1:0] n);
    int m;
    m = (lvl(p) > lvl(n)) ? lvl(p) : lvl(n);
    return 2 - m;
  endfunction

  function automatic int loc(int a, int b);
    return (a + b) % DEPTH;
  endfunction

  task automatic record(int a, int b, logic [1:0] p, logic [1:0] n);
    cyc_da = 0; cyc_ad = 1; smp_addr = a[AW-1:0]; bank_sel = b[BW-1:0];
    pk_pos = p; pk_neg = n; smp_stb = 1;
    tick();
    smp_stb = 0;
    model[loc(a, b)] = exp_code(p, n);
  endtask

  task automatic playback(int a, int b, string req);
    cyc_da = 1; cyc_ad = 0; smp_addr = a[AW-1:0]; bank_sel = b[BW-1:0];
    rd_stb = 1; tick();
    rd_stb = 0; tick();
    chk(req, att_code, model[loc(a, b)]);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 0;
    tick(); tick();
    // R9: reset state
    chk("R9 att_code", att_code, 0);
    chk("R9 cyc_err", cyc_err, 0);
    rst_n = 1; tick();

    // R2, R5, R1: all peak flag combinations through A/D path
    for (int v = 0; v < 16; v++) begin
      record(v, 0, v[3:2], v[1:0]);
      tick();
      chk("R2/R5 live code", att_code, exp_code(v[3:2], v[1:0]));
      chk("R1 no code 3", int'(att_code == 2'b11), 0);
    end

    // R2: no strobe -> live code held despite peak change
    record(0, 0, 2'b00, 2'b00);  // code 2
    pk_pos = 2'b11; tick(); tick();
    chk("R2 hold without strobe", att_code, 2);

    // R3, R10, R6: per-bank writes at same address then read back
    for (int b = 0; b < 4; b++) record(10, b, 2'(b), 2'b00);
    record(63, 3, 2'b10, 2'b00);  // wraps to 2
    for (int b = 0; b < 4; b++) playback(10, b, "R3/R10/R6 bank readback");
    playback(63, 3, "R10 wrap readback");
    chk("R10 wrap location", model[2], 0);

    // R3: strobe during D/A does not write
    record(20, 0, 2'b00, 2'b00);  // code 2 stored
    cyc_da = 1; cyc_ad = 0; smp_addr = 20; bank_sel = 0;
    pk_pos = 2'b10; smp_stb = 1; tick(); smp_stb = 0;
    playback(20, 0, "R3 no write in D/A");
    chk("R3 stored unchanged", att_code, 2);

    // R4: held-high read strobe does not re-fetch
    record(30, 0, 2'b01, 2'b00);  // code 1
    playback(30, 0, "R4 setup");
    rd_stb = 1; smp_addr = 10; tick();     // rising: loads mem[10] = 2
    smp_addr = 30; tick(); tick();          // held high: no refetch
    chk("R4 no refetch while high", att_code, model[10]);
    rd_stb = 0; tick();

    // R7, R8: illegal cycle lines
    playback(30, 0, "R6 before illegal");
    cyc_da = 1; cyc_ad = 1; smp_addr = 10; rd_stb = 1; tick(); rd_stb = 0; tick();
    chk("R7 hold on 11", att_code, 1);
    chk("R8 err on 11", cyc_err, 1);
    cyc_da = 0; cyc_ad = 0; tick();
    chk("R7 hold on 00", att_code, 1);
    chk("R8 err on 00", cyc_err, 1);
    cyc_da = 1; tick();
    chk("R8 err clears", cyc_err, 0);
    chk("R6 stored after illegal", att_code, model[10]);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule